// File: doc/BRIEF.md
# Peripheral DMA Channel

This block is one memory-mapped DMA channel that copies data between memory and a peripheral data port. Software sets it up through a small register file. A global word holds a master enable. The channel has four words: a first control word with enable, pause, request line, burst code and block count; a second control word with beat width, mode, address-hold flags, interrupt enables and a stop-status field; and the live source and destination addresses.

Once the first control word is written with its enable bit set, the channel runs beats on a simple request/ready master port. Each beat is one read from the source address followed by one write to the destination address. Data is right-justified on the bus, and `m_size_o` gives the beat width. The burst code sets how many beats form a block, and the count field sets how many blocks are moved. After each beat, any address that is not held advances by the beat width, so reading an address register mid-transfer shows progress. When the channel finishes, or when the bus returns an error, it clears its own enable, records a stop code, and can raise an interrupt.

Top module: `pdma_channel`

## Requirements
- R1: Register offsets are: global control 0x00, control A 0x10, control B 0x14, source address 0x18, destination address 0x1C. After reset every register reads zero, `irq_o` is low and `m_req_o` is low.
- R2: A transfer starts only on a write to control A with bit 31 (enable) set while the channel is idle. It issues bus requests only while global bit 31, control A bit 31 and not control A bit 30 all hold.
- R3: Control A bits 23:20 select the beats per block: 0xF gives 16, 0xD gives 8, 0xB gives 4, and any other code gives 1.
- R4: The channel moves (bits 15:0 of control A + 1) blocks. The total byte count is blocks × beats × beat width.
- R5: Control B bits 27:26 set the beat width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. This code appears on `m_size_o` with every request.
- R6: Control B bit 25 holds the source address and bit 24 holds the destination address. After each accepted write beat, an address that is not held grows by the beat width. Reads of offsets 0x18/0x1C return the live values, so the bytes moved equal the current address minus the start address.
- R7: Setting control A bit 30 stops requests and freezes both addresses. Clearing it resumes from the frozen addresses, and the final memory image matches an uninterrupted transfer.
- R8: Clearing control A bit 31 during a transfer aborts it. There are no further requests, the addresses stay frozen, and stop status stays unchanged.
- R9: On completion, control B bits 18:16 become 5 and control A bit 31 clears. `irq_o` is high only if control B bit 19 is set.
- R10: An error response (`m_err_i` with `m_ready_i`) ends the transfer without advancing addresses. Stop status becomes 2 and control A bit 31 clears. `irq_o` is high only if control B bit 20 is set.
- R11: Writing control B with zeros in bits 18:16 clears stop status, and `irq_o` drops. Writing ones there leaves stop status unchanged.
- R12: Each beat reads the source address, then writes the captured data to the destination address on a later request. The destination memory holds the source bytes in beat order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Register byte offset |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data for `cfg_addr_i` (combinational) |
| m_req_o | output | 1 | Master beat request |
| m_we_o | output | 1 | 1 = write beat, 0 = read beat |
| m_addr_o | output | 32 | Beat byte address |
| m_size_o | output | 2 | Beat width code |
| m_wdata_o | output | 32 | Write data, right-justified |
| m_ready_i | input | 1 | Beat accepted this cycle |
| m_rdata_i | input | 32 | Read data, right-justified |
| m_err_i | input | 1 | Error response, valid with `m_ready_i` |
| irq_o | output | 1 | Channel interrupt |

## Verification
Checked on every cycle:
- requests never appear unless the global enable, channel enable and pause settings allow them;
- a paused channel keeps both addresses steady;
- a moving source address grows by exactly the beat width per accepted write;
- an error response always drops the enable;
- the interrupt rises only with the enable clear and a nonzero stop code.

Only the bench scenarios can show the rest:
- the copied memory image for each burst code, width and address-hold combination, including transfers with ready stalls;
- the effect of interrupt enables, and that resume after a pause lands on the same final image;
- that an abort leaves status untouched.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
    localparam logic [2:0] STOP_DONE = 3'd5;
    localparam logic [2:0] STOP_ERR  = 3'd2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RD   = 2'd1,
        PH_WR   = 2'd2
    } phase_e;
endpackage

// File: rtl/pdma_burst_decode.sv
module pdma_burst_decode #(
    parameter int BCW = 4
) (
    input  logic [3:0]     code_i,
    output logic [BCW-1:0] beats_m1_o
);
    always_comb begin
        case (code_i)
            4'hF:    beats_m1_o = BCW'(15);
            4'hD:    beats_m1_o = BCW'(7);
            4'hB:    beats_m1_o = BCW'(3);
            default: beats_m1_o = '0;
        endcase
    end
endmodule

// File: rtl/pdma_engine.sv
module pdma_engine
    import pdma_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int TCW = 16,
    parameter int BCW = 4
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           start_i,
    input  logic           run_i,
    input  logic           abort_i,
    input  logic [TCW-1:0] tc_i,
    input  logic [BCW-1:0] beats_m1_i,
    input  logic [AW-1:0]  src_i,
    input  logic [AW-1:0]  dst_i,
    output logic           m_req_o,
    output logic           m_we_o,
    output logic [AW-1:0]  m_addr_o,
    output logic [DW-1:0]  m_wdata_o,
    input  logic           m_ready_i,
    input  logic [DW-1:0]  m_rdata_i,
    input  logic           m_err_i,
    output logic           beat_done_o,
    output logic           done_o,
    output logic           err_o,
    output logic           busy_o
);
    typedef struct packed {
        phase_e         ph;
        logic [TCW-1:0] blk;
        logic [BCW-1:0] beat;
        logic [BCW-1:0] reload;
        logic [DW-1:0]  data;
    } eng_t;

    eng_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        m_req_o     = 1'b0;
        m_we_o      = 1'b0;
        m_addr_o    = src_i;
        m_wdata_o   = st_q.data;
        beat_done_o = 1'b0;
        done_o      = 1'b0;
        err_o       = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.ph     = PH_RD;
                    st_d.blk    = tc_i;
                    st_d.beat   = beats_m1_i;
                    st_d.reload = beats_m1_i;
                end
            end
            PH_RD: begin
                if (abort_i) begin
                    st_d.ph = PH_IDLE;
                end else if (run_i) begin
                    m_req_o = 1'b1;
                    if (m_ready_i) begin
                        if (m_err_i) begin
                            err_o   = 1'b1;
                            st_d.ph = PH_IDLE;
                        end else begin
                            st_d.data = m_rdata_i;
                            st_d.ph   = PH_WR;
                        end
                    end
                end
            end
            PH_WR: begin
                if (abort_i) begin
                    st_d.ph = PH_IDLE;
                end else if (run_i) begin
                    m_req_o  = 1'b1;
                    m_we_o   = 1'b1;
                    m_addr_o = dst_i;
                    if (m_ready_i) begin
                        if (m_err_i) begin
                            err_o   = 1'b1;
                            st_d.ph = PH_IDLE;
                        end else begin
                            beat_done_o = 1'b1;
                            if (st_q.beat != '0) begin
                                st_d.beat = st_q.beat - 1'b1;
                                st_d.ph   = PH_RD;
                            end else if (st_q.blk != '0) begin
                                st_d.blk  = st_q.blk - 1'b1;
                                st_d.beat = st_q.reload;
                                st_d.ph   = PH_RD;
                            end else begin
                                done_o  = 1'b1;
                                st_d.ph = PH_IDLE;
                            end
                        end
                    end
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    assign busy_o = (st_q.ph != PH_IDLE);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/pdma_channel.sv
module pdma_channel
    import pdma_pkg::*;
#(
    parameter int          AW      = 32,
    parameter int          DW      = 32,
    parameter int          TCW     = 16,
    parameter int          BCW     = 4,
    parameter int          RAW     = 8,
    parameter logic [7:0]  CH_BASE = 8'h10
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           cfg_we_i,
    input  logic [RAW-1:0] cfg_addr_i,
    input  logic [31:0]    cfg_wdata_i,
    output logic [31:0]    cfg_rdata_o,
    output logic           m_req_o,
    output logic           m_we_o,
    output logic [AW-1:0]  m_addr_o,
    output logic [1:0]     m_size_o,
    output logic [DW-1:0]  m_wdata_o,
    input  logic           m_ready_i,
    input  logic [DW-1:0]  m_rdata_i,
    input  logic           m_err_i,
    output logic           irq_o
);
    localparam logic [RAW-1:0] OFS_GCTL = '0;
    localparam logic [RAW-1:0] OFS_CA   = RAW'(CH_BASE);
    localparam logic [RAW-1:0] OFS_CB   = RAW'(CH_BASE + 8'h4);
    localparam logic [RAW-1:0] OFS_SRC  = RAW'(CH_BASE + 8'h8);
    localparam logic [RAW-1:0] OFS_DST  = RAW'(CH_BASE + 8'hC);

    typedef struct packed {
        logic           gen;
        logic           en;
        logic           pause;
        logic [4:0]     line;
        logic [3:0]     bt;
        logic [TCW-1:0] tc;
        logic [1:0]     mode;
        logic [1:0]     width;
        logic           fs;
        logic           fd;
        logic           ei;
        logic           ci;
        logic [2:0]     ss;
        logic [AW-1:0]  src;
        logic [AW-1:0]  dst;
    } regs_t;

    regs_t regs_d, regs_q;

    logic           start, run, busy;
    logic           beat_done, done, err;
    logic [BCW-1:0] beats_m1;
    logic [AW-1:0]  step;

    // Names the bound checker observes.
    logic          gen_on, ch_en, ch_pause, fix_src, fix_dst;
    logic [1:0]    bw_code;
    logic [2:0]    stop_st;
    logic [AW-1:0] src_cur, dst_cur;

    pdma_burst_decode #(.BCW(BCW)) u_dec (
        .code_i     (regs_q.bt),
        .beats_m1_o (beats_m1)
    );

    pdma_engine #(.AW(AW), .DW(DW), .TCW(TCW), .BCW(BCW)) u_eng (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (start),
        .run_i       (run),
        .abort_i     (!regs_q.en),
        .tc_i        (regs_d.tc),
        .beats_m1_i  (beats_m1_next),
        .src_i       (regs_q.src),
        .dst_i       (regs_q.dst),
        .m_req_o     (m_req_o),
        .m_we_o      (m_we_o),
        .m_addr_o    (m_addr_o),
        .m_wdata_o   (m_wdata_o),
        .m_ready_i   (m_ready_i),
        .m_rdata_i   (m_rdata_i),
        .m_err_i     (m_err_i),
        .beat_done_o (beat_done),
        .done_o      (done),
        .err_o       (err),
        .busy_o      (busy)
    );

    assign run  = regs_q.gen && regs_q.en && !regs_q.pause;
    assign step = (regs_q.width == 2'd0) ? AW'(1) :
                  (regs_q.width == 2'd1) ? AW'(2) : AW'(4);

    always_comb begin
        regs_d = regs_q;
        start  = 1'b0;
        if (cfg_we_i) begin
            case (cfg_addr_i)
                OFS_GCTL: regs_d.gen = cfg_wdata_i[31];
                OFS_CA: begin
                    regs_d.en    = cfg_wdata_i[31];
                    regs_d.pause = cfg_wdata_i[30];
                    regs_d.line  = cfg_wdata_i[28:24];
                    regs_d.bt    = cfg_wdata_i[23:20];
                    regs_d.tc    = cfg_wdata_i[TCW-1:0];
                    start        = cfg_wdata_i[31] && !busy;
                end
                OFS_CB: begin
                    regs_d.mode  = cfg_wdata_i[29:28];
                    regs_d.width = cfg_wdata_i[27:26];
                    regs_d.fs    = cfg_wdata_i[25];
                    regs_d.fd    = cfg_wdata_i[24];
                    regs_d.ei    = cfg_wdata_i[20];
                    regs_d.ci    = cfg_wdata_i[19];
                    regs_d.ss    = regs_q.ss & cfg_wdata_i[18:16];
                end
                OFS_SRC: regs_d.src = AW'(cfg_wdata_i);
                OFS_DST: regs_d.dst = AW'(cfg_wdata_i);
                default: ;
            endcase
        end
        if (beat_done) begin
            if (!regs_q.fs) regs_d.src = regs_q.src + step;
            if (!regs_q.fd) regs_d.dst = regs_q.dst + step;
        end
        if (done) begin
            regs_d.ss = STOP_DONE;
            regs_d.en = 1'b0;
        end
        if (err) begin
            regs_d.ss = STOP_ERR;
            regs_d.en = 1'b0;
        end
    end

    // Burst length for a start comes from the value being written.
    logic [BCW-1:0] beats_m1_next;
    pdma_burst_decode #(.BCW(BCW)) u_dec_next (
        .code_i     (regs_d.bt),
        .beats_m1_o (beats_m1_next)
    );

    always_comb begin
        case (cfg_addr_i)
            OFS_GCTL: cfg_rdata_o = {regs_q.gen, 31'b0};
            OFS_CA:   cfg_rdata_o = {regs_q.en, regs_q.pause, 1'b0, regs_q.line,
                                     regs_q.bt, 4'b0, 16'(regs_q.tc)};
            OFS_CB:   cfg_rdata_o = {2'b0, regs_q.mode, regs_q.width, regs_q.fs,
                                     regs_q.fd, 3'b0, regs_q.ei, regs_q.ci,
                                     regs_q.ss, 16'b0};
            OFS_SRC:  cfg_rdata_o = 32'(regs_q.src);
            OFS_DST:  cfg_rdata_o = 32'(regs_q.dst);
            default:  cfg_rdata_o = '0;
        endcase
    end

    assign m_size_o = regs_q.width;
    assign irq_o    = ((regs_q.ss == STOP_DONE) && regs_q.ci) ||
                      ((regs_q.ss == STOP_ERR)  && regs_q.ei);

    assign gen_on   = regs_q.gen;
    assign ch_en    = regs_q.en;
    assign ch_pause = regs_q.pause;
    assign fix_src  = regs_q.fs;
    assign fix_dst  = regs_q.fd;
    assign bw_code  = regs_q.width;
    assign stop_st  = regs_q.ss;
    assign src_cur  = regs_q.src;
    assign dst_cur  = regs_q.dst;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end
endmodule

// File: rtl/pdma_channel_chk.sv
module pdma_channel_chk #(
    parameter int AW = 32
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          cfg_we_i,
    input logic          gen_i,
    input logic          en_i,
    input logic          pause_i,
    input logic          fs_i,
    input logic          fd_i,
    input logic [1:0]    bw_i,
    input logic [2:0]    ss_i,
    input logic [AW-1:0] src_i,
    input logic [AW-1:0] dst_i,
    input logic          m_req_i,
    input logic          m_we_i,
    input logic          m_ready_i,
    input logic          m_err_i,
    input logic          irq_i
);
    logic [AW-1:0] bytes_per_beat;
    always_comb begin
        case (bw_i)
            2'd0:    bytes_per_beat = AW'(1);
            2'd1:    bytes_per_beat = AW'(2);
            default: bytes_per_beat = AW'(4);
        endcase
    end

    logic wr_ok;
    assign wr_ok = m_req_i && m_we_i && m_ready_i && !m_err_i && !cfg_we_i;

    // R2: requests only with both enables and no pause
    a_r2_req_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        m_req_i |-> (gen_i && en_i && !pause_i));

    // R7: paused channel freezes both addresses
    a_r7_pause_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && pause_i && !cfg_we_i) |=> ($stable(src_i) && $stable(dst_i)));

    // R6: moving source grows by one beat width per accepted write
    a_r6_src_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_ok && !fs_i) |=> (src_i == $past(src_i) + $past(bytes_per_beat)));

    // R6: moving destination grows by one beat width per accepted write
    a_r6_dst_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_ok && !fd_i) |=> (dst_i == $past(dst_i) + $past(bytes_per_beat)));

    // R10: error response drops the enable
    a_r10_err_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (m_req_i && m_ready_i && m_err_i && !cfg_we_i) |=> !en_i);

    // R9: interrupt rises only after the channel has cleared its enable
    a_r9_irq_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_i) |-> !en_i);

    // R11: interrupt implies a recorded stop code
    a_r11_irq_has_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i |-> (ss_i != 3'd0));
endmodule

bind pdma_channel pdma_channel_chk #(.AW(AW)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_we_i  (cfg_we_i),
    .gen_i     (gen_on),
    .en_i      (ch_en),
    .pause_i   (ch_pause),
    .fs_i      (fix_src),
    .fd_i      (fix_dst),
    .bw_i      (bw_code),
    .ss_i      (stop_st),
    .src_i     (src_cur),
    .dst_i     (dst_cur),
    .m_req_i   (m_req_o),
    .m_we_i    (m_we_o),
    .m_ready_i (m_ready_i),
    .m_err_i   (m_err_i),
    .irq_i     (irq_o)
);

// File: tb/pdma_channel_test.sv
`timescale 1ns/1ps
module pdma_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        m_req, m_we, m_ready, m_err;
    logic [31:0] m_addr, m_wdata, m_rdata;
    logic [1:0]  m_size;
    logic        irq;

    always #2 clk = ~clk;

    pdma_channel uut (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
        .cfg_rdata_o(cfg_rdata),
        .m_req_o(m_req), .m_we_o(m_we), .m_addr_o(m_addr), .m_size_o(m_size),
        .m_wdata_o(m_wdata), .m_ready_i(m_ready), .m_rdata_i(m_rdata),
        .m_err_i(m_err), .irq_o(irq)
    );

    // ---------------- memory model ----------------
    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    logic       stall_on = 1'b0;
    logic       err_on = 1'b0;
    logic [7:0] err_addr = '0;
    logic [1:0] stall_cnt = '0;
    int         req_cnt = 0, wr_cnt = 0, size_bad = 0;
    logic [1:0] exp_w = '0;

    assign m_ready = !stall_on || (stall_cnt == 2'b11);
    assign m_err   = err_on && m_req && !m_we && (m_addr[7:0] == err_addr);

    always_comb begin
        m_rdata = '0;
        for (int k = 0; k < 4; k++)
            if (k < (1 << m_size)) m_rdata[k*8 +: 8] = mem[8'(m_addr[7:0] + k)];
    end

    always @(posedge clk) begin
        stall_cnt <= stall_cnt + 2'd1;
        if (m_req) begin
            req_cnt = req_cnt + 1;
            if (m_size != exp_w) size_bad = size_bad + 1;
        end
        if (m_req && m_we && m_ready && !m_err) begin
            wr_cnt = wr_cnt + 1;
            for (int k = 0; k < 4; k++)
                if (k < (1 << m_size)) mem[8'(m_addr[7:0] + k)] = m_wdata[k*8 +: 8];
        end
    end

    // ---------------- bookkeeping ----------------
    int total = 0, bad = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic wait_irq(input int lim, output bit seen);
        seen = 1'b0;
        for (int c = 0; c < lim; c++) begin
            @(negedge clk);
            if (irq) begin seen = 1'b1; break; end
        end
    endtask

    task automatic wait_idle(input int lim);
        logic [31:0] v;
        for (int c = 0; c < lim; c++) begin
            rd(8'h10, v);
            if (!v[31]) break;
        end
    endtask

    task automatic init_mem();
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i * 13 + 5);
            exp_mem[i] = 8'(i * 13 + 5);
        end
    endtask

    function automatic int beats_of(input logic [3:0] code);
        case (code)
            4'hF: return 16;
            4'hD: return 8;
            4'hB: return 4;
            default: return 1;
        endcase
    endfunction

    // reference copy: beat by beat, read from source then write to destination
    task automatic model(input logic [3:0] bt, input logic [15:0] tc, input logic [1:0] w,
                         input logic fs, input logic fd, input logic [7:0] s0,
                         input logic [7:0] d0, input int nbeats_lim);
        logic [7:0] s, d, t [4];
        int wb, n;
        s = s0; d = d0; wb = 1 << w;
        n = (int'(tc) + 1) * beats_of(bt);
        if (nbeats_lim >= 0 && nbeats_lim < n) n = nbeats_lim;
        for (int b = 0; b < n; b++) begin
            for (int k = 0; k < wb; k++) t[k] = exp_mem[8'(s + k)];
            for (int k = 0; k < wb; k++) exp_mem[8'(d + k)] = t[k];
            if (!fs) s = 8'(s + wb);
            if (!fd) d = 8'(d + wb);
        end
    endtask

    task automatic chk_mem(input string req);
        int miss = 0, first = -1;
        for (int i = 0; i < 256; i++)
            if (mem[i] !== exp_mem[i]) begin
                miss++;
                if (first < 0) first = i;
            end
        chk(req, miss, 0);
        if (miss != 0) $display("  first mismatch at byte %0h", first);
    endtask

    function automatic logic [31:0] cb_word(input logic [1:0] w, input logic fs, input logic fd,
                                            input logic ei, input logic ci);
        return {2'b0, 2'd2, w, fs, fd, 3'b0, ei, ci, 3'b0, 16'b0};
    endfunction

    function automatic logic [31:0] ca_word(input logic en, input logic pause,
                                            input logic [3:0] bt, input logic [15:0] tc);
        return {en, pause, 1'b0, 5'd3, bt, 4'b0, tc};
    endfunction

    task automatic setup(input logic [3:0] bt, input logic [15:0] tc, input logic [1:0] w,
                         input logic fs, input logic fd, input logic [7:0] s, input logic [7:0] d,
                         input logic ei, input logic ci, input logic gen);
        exp_w = w;
        wr(8'h00, {gen, 31'b0});
        wr(8'h14, cb_word(w, fs, fd, ei, ci));
        wr(8'h18, {24'b0, s});
        wr(8'h1C, {24'b0, d});
        wr_cnt = 0;
        wr(8'h10, ca_word(1'b1, 1'b0, bt, tc));
    endtask

    // ---------------- vector table ----------------
    typedef struct packed {
        logic [3:0]  bt;
        logic [15:0] tc;
        logic [1:0]  w;
        logic        fs;
        logic        fd;
        logic [7:0]  src;
        logic [7:0]  dst;
        logic        stall;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{4'hF, 16'd0, 2'd0, 1'b0, 1'b0, 8'h00, 8'h80, 1'b0},
        '{4'hD, 16'd1, 2'd1, 1'b0, 1'b0, 8'h10, 8'h90, 1'b1},
        '{4'hB, 16'd2, 2'd2, 1'b0, 1'b0, 8'h20, 8'hB0, 1'b0},
        '{4'h3, 16'd4, 2'd2, 1'b1, 1'b0, 8'h40, 8'hE0, 1'b0},
        '{4'hB, 16'd0, 2'd1, 1'b0, 1'b1, 8'h50, 8'hF8, 1'b1},
        '{4'h0, 16'd2, 2'd0, 1'b0, 1'b0, 8'h60, 8'h70, 1'b1}
    };

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [31:0] v, a0, a1;
        vec_t        tv;
        bit          seen;
        int          nb, wbytes, rq0;

        init_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(8'h00, v); chk("R1 gctl", v, 32'h0);
        rd(8'h10, v); chk("R1 ctlA", v, 32'h0);
        rd(8'h14, v); chk("R1 ctlB", v, 32'h0);
        rd(8'h18, v); chk("R1 src", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 req", {31'b0, m_req}, 32'h0);

        // table-driven transfers
        for (int i = 0; i < NV; i++) begin
            tv = VECS[i];
            init_mem();
            stall_on = tv.stall;
            nb = (int'(tv.tc) + 1) * beats_of(tv.bt);
            wbytes = nb * (1 << tv.w);
            model(tv.bt, tv.tc, tv.w, tv.fs, tv.fd, tv.src, tv.dst, -1);
            setup(tv.bt, tv.tc, tv.w, tv.fs, tv.fd, tv.src, tv.dst, 1'b1, 1'b1, 1'b1);
            wait_irq(4000, seen);
            chk("R9 irq raised", {31'b0, seen}, 32'h1);
            chk("R3 beat count", wr_cnt, nb);
            rd(8'h14, v); chk("R9 stop code", {29'b0, v[18:16]}, 32'h5);
            rd(8'h10, v); chk("R9 enable cleared", {31'b0, v[31]}, 32'h0);
            rd(8'h18, v);
            chk("R6 src final", v, {24'b0, tv.fs ? tv.src : 8'(tv.src + wbytes)});
            rd(8'h1C, v);
            chk("R4 dst final", v, {24'b0, tv.fd ? tv.dst : 8'(tv.dst + wbytes)});
            chk_mem("R12 memory image");
            chk("R5 size code", size_bad, 0);
            wr(8'h14, cb_word(tv.w, tv.fs, tv.fd, 1'b1, 1'b1));
            @(negedge clk);
            chk("R11 irq cleared", {31'b0, irq}, 32'h0);
            stall_on = 1'b0;
        end

        // R11: writing ones keeps the status
        init_mem();
        setup(4'h0, 16'd0, 2'd0, 1'b0, 1'b0, 8'h00, 8'h80, 1'b1, 1'b1, 1'b1);
        wait_irq(200, seen);
        wr(8'h14, {cb_word(2'd0, 1'b0, 1'b0, 1'b1, 1'b1)} | 32'h0007_0000);
        rd(8'h14, v); chk("R11 ones keep status", {29'b0, v[18:16]}, 32'h5);
        wr(8'h14, cb_word(2'd0, 1'b0, 1'b0, 1'b1, 1'b1));

        // R2: no requests without the global enable
        init_mem();
        rq0 = req_cnt;
        setup(4'hB, 16'd0, 2'd0, 1'b0, 1'b0, 8'h00, 8'h80, 1'b1, 1'b1, 1'b0);
        repeat (20) @(negedge clk);
        chk("R2 idle without global enable", req_cnt - rq0, 0);
        model(4'hB, 16'd0, 2'd0, 1'b0, 1'b0, 8'h00, 8'h80, -1);
        wr(8'h00, 32'h8000_0000);
        wait_irq(400, seen);
        chk("R2 runs after global enable", {31'b0, seen}, 32'h1);
        chk_mem("R2 memory image");
        wr(8'h14, cb_word(2'd0, 1'b0, 1'b0, 1'b1, 1'b1));

        // R9: completion without interrupt enable
        init_mem();
        setup(4'hB, 16'd0, 2'd0, 1'b0, 1'b0, 8'h00, 8'h80, 1'b1, 1'b0, 1'b1);
        wait_idle(400);
        rd(8'h14, v); chk("R9 status without ci", {29'b0, v[18:16]}, 32'h5);
        chk("R9 irq masked", {31'b0, irq}, 32'h0);
        wr(8'h14, cb_word(2'd0, 1'b0, 1'b0, 1'b1, 1'b1));

        // R7: pause and resume
        init_mem();
        model(4'hF, 16'd3, 2'd0, 1'b0, 1'b0, 8'h00, 8'h80, -1);
        setup(4'hF, 16'd3, 2'd0, 1'b0, 1'b0, 8'h00, 8'h80, 1'b1, 1'b1, 1'b1);
        repeat (20) @(negedge clk);
        wr(8'h10, ca_word(1'b1, 1'b1, 4'hF, 16'd3));
        repeat (2) @(negedge clk);
        rd(8'h18, a0);
        rq0 = req_cnt;
        repeat (10) @(negedge clk);
        rd(8'h18, a1);
        chk("R7 src frozen", a1, a0);
        chk("R7 no requests", req_cnt - rq0, 0);
        chk("R6 live progress", a0, wr_cnt);
        chk("R6 progress nonzero", {31'b0, (a0 > 0 && a0 < 64)}, 32'h1);
        wr(8'h10, ca_word(1'b1, 1'b0, 4'hF, 16'd3));
        wait_irq(1000, seen);
        chk("R7 resumed to completion", {31'b0, seen}, 32'h1);
        chk_mem("R7 memory image");
        wr(8'h14, cb_word(2'd0, 1'b0, 1'b0, 1'b1, 1'b1));

        // R8: abort
        init_mem();
        setup(4'hF, 16'd3, 2'd0, 1'b0, 1'b0, 8'h00, 8'h80, 1'b1, 1'b1, 1'b1);
        repeat (20) @(negedge clk);
        wr(8'h10, ca_word(1'b0, 1'b0, 4'hF, 16'd3));
        repeat (2) @(negedge clk);
        rd(8'h1C, a0);
        rq0 = req_cnt;
        repeat (10) @(negedge clk);
        rd(8'h1C, a1);
        chk("R8 dst frozen", a1, a0);
        chk("R8 no requests", req_cnt - rq0, 0);
        rd(8'h14, v); chk("R8 status unchanged", {29'b0, v[18:16]}, 32'h0);
        chk("R8 no irq", {31'b0, irq}, 32'h0);

        // R10: error with interrupt enabled
        init_mem();
        model(4'hF, 16'd0, 2'd0, 1'b0, 1'b0, 8'h00, 8'h80, 8);
        err_on = 1'b1; err_addr = 8'h08;
        setup(4'hF, 16'd0, 2'd0, 1'b0, 1'b0, 8'h00, 8'h80, 1'b1, 1'b1, 1'b1);
        wait_irq(400, seen);
        chk("R10 irq on error", {31'b0, seen}, 32'h1);
        rd(8'h14, v); chk("R10 error code", {29'b0, v[18:16]}, 32'h2);
        rd(8'h10, v); chk("R10 enable cleared", {31'b0, v[31]}, 32'h0);
        rd(8'h18, v); chk("R10 src at fault", v, 32'h8);
        chk_mem("R10 partial image");
        wr(8'h14, cb_word(2'd0, 1'b0, 1'b0, 1'b1, 1'b1));
        @(negedge clk);
        chk("R11 irq cleared after error", {31'b0, irq}, 32'h0);

        // R10: error with interrupt disabled
        init_mem();
        setup(4'hF, 16'd0, 2'd0, 1'b0, 1'b0, 8'h00, 8'h80, 1'b0, 1'b1, 1'b1);
        wait_idle(400);
        rd(8'h14, v); chk("R10 error code, ei off", {29'b0, v[18:16]}, 32'h2);
        chk("R10 irq masked", {31'b0, irq}, 32'h0);
        err_on = 1'b0;

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule